// File: doc/BRIEF.md
# Free-Running Elastic Clock-Domain FIFO

This block carries an unbroken stream of words from a user write clock to an independent transmit read clock. Neither side has a handshake. Each write-clock cycle stores the word on `wrData`, and each read-clock cycle presents the next stored word on `rdData`. Reset primes the buffer at exactly half full, so small phase wander between two clocks of the same frequency is absorbed in both directions.

Only one bit reports occupancy. `halfMark` goes high once the read side sees more than half of the entries in use. If the two clocks really differ in frequency, the buffer drifts until a write would overwrite an unread entry or a read would fetch an unwritten one. Either case raises `slipError`, which stays set until the next reset, and the output words are forced to zero for as long as it is set. Pointers cross between the domains in Gray code through synchronizer chains. Each domain releases the shared asynchronous reset on its own clock.

Top module: `elasticTxFifo`

## Requirements
- R1: With no enable input, one word is stored on every `wrClk` cycle and one word is presented on every `rdClk` cycle. Words leave in the order they entered.
- R2: After reset the buffer holds DEPTH/2 entries of zero. The first DEPTH/2 words read are 0, and the next word read is the first word written.
- R3: When both clocks run at the same frequency, at any phase offset, `slipError` stays 0 and `halfMark` stays 0.
- R4: `halfMark` is a register in the read domain. It is 1 when the read-side occupancy (synchronized write pointer minus read pointer) exceeds DEPTH/2. When writes steadily outpace reads, it rises before `slipError` does.
- R5: When the write clock is faster than the read clock, overflow is detected in the write domain (a write about to land on an unread entry) and `slipError` rises.
- R6: When the write clock is slower than the read clock, underflow is detected in the read domain (a read about to take an unwritten entry) and `slipError` rises. `halfMark` does not rise during this drain.
- R7: Once set, `slipError` stays at 1 until reset, even if the clocks return to equal rates.
- R8: While `slipError` is 1, `rdData` is all zeros.
- R9: Asserting `rstN` low clears `rdData`, `halfMark` and `slipError` immediately. Each domain leaves reset on its own clock after SYNC_STAGES edges, so the first active edge is edge SYNC_STAGES+1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrData | input | DATA_W | Word stored on every write-clock edge |
| rdClk | input | 1 | Read-domain clock |
| rdData | output | DATA_W | Word read out, registered in the read domain; zero while a slip is flagged |
| halfMark | output | 1 | Read-domain watermark: more than half the entries in use |
| slipError | output | 1 | Sticky overflow/underflow flag, read domain |

## Verification
The bench builds the block with its defaults: 16-bit words, 16 entries (ADDR_W of 4) and two-stage synchronizers. A 16-entry buffer gives enough spacing between the watermark point and the overflow point that the watermark's lead over the slip can be observed. It is also shallow enough that a 20 to 25 percent rate mismatch overflows or drains it within a few dozen read cycles. Equal-rate runs at two phase offsets, with random, alternating and counting data, follow every word through the primed zeros and out in order. Overflow and underflow runs then check the watermark ordering, the stickiness after the rates match again, and the zeroed output.

// File: rtl/elasticFifoPkg.sv
`timescale 1ns/1ps
package elasticFifoPkg;

  // write-domain strobe from control to datapath
  typedef struct packed {
    logic store;   // commit wrData into the addressed entry
  } wrStrobe_t;

  // read-domain strobe from control to datapath
  typedef struct packed {
    logic squash;  // force the outgoing word to zero
  } rdStrobe_t;

endpackage

// File: rtl/elasticResetSync.sv
`timescale 1ns/1ps
module elasticResetSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncRstN,
  output logic syncRstN
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge asyncRstN) begin
    if (!asyncRstN) chain <= '0;
    else            chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncRstN = chain[STAGES-1];

endmodule

// File: rtl/elasticCtrl.sv
`timescale 1ns/1ps
module elasticCtrl
  import elasticFifoPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              rdClk,
  input  logic              rdRstN,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb,
  output logic              halfMark,
  output logic              slipError
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [PTR_W-1:0] DEPTH_P   = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P    = PTR_W'(HALF);
  localparam logic [PTR_W-1:0] HALF_GRAY = HALF_P ^ (HALF_P >> 1);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wBin, wBinNext, wGray;
  logic [PTR_W-1:0] rGrayAtW [SYNC_STAGES];
  logic [PTR_W-1:0] rBinAtW, wOcc;
  logic             wouldOverrun, overflowW;

  // read-domain signals declared ahead of use
  logic [PTR_W-1:0] rBin, rBinNext, rGray;
  logic [PTR_W-1:0] wGrayAtR [SYNC_STAGES];
  logic [PTR_W-1:0] wBinAtR, rOcc;
  logic             wouldStarve, underflowR;
  logic [SYNC_STAGES-1:0] ovfAtR;

  assign wBinNext = wBin + 1'b1;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wBin  <= HALF_P;
      wGray <= HALF_GRAY;
    end else begin
      wBin  <= wBinNext;
      wGray <= toGray(wBinNext);
    end
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) rGrayAtW[s] <= '0;
    end else begin
      rGrayAtW[0] <= rGray;
      for (int s = 1; s < SYNC_STAGES; s++) rGrayAtW[s] <= rGrayAtW[s-1];
    end
  end

  assign rBinAtW      = fromGray(rGrayAtW[SYNC_STAGES-1]);
  assign wOcc         = wBin - rBinAtW;
  assign wouldOverrun = (wOcc == DEPTH_P);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN)           overflowW <= 1'b0;
    else if (wouldOverrun) overflowW <= 1'b1;
  end

  assign wrAddr      = wBin[ADDR_W-1:0];
  assign wrStb.store = !(overflowW || wouldOverrun);

  // ---------------- read domain ----------------
  assign rBinNext = rBin + 1'b1;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else begin
      rBin  <= rBinNext;
      rGray <= toGray(rBinNext);
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) wGrayAtR[s] <= HALF_GRAY;
      ovfAtR <= '0;
    end else begin
      wGrayAtR[0] <= wGray;
      for (int s = 1; s < SYNC_STAGES; s++) wGrayAtR[s] <= wGrayAtR[s-1];
      ovfAtR <= {ovfAtR[SYNC_STAGES-2:0], overflowW};
    end
  end

  assign wBinAtR     = fromGray(wGrayAtR[SYNC_STAGES-1]);
  assign rOcc        = wBinAtR - rBin;
  assign wouldStarve = (rOcc == '0);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      underflowR <= 1'b0;
      halfMark   <= 1'b0;
    end else begin
      if (wouldStarve) underflowR <= 1'b1;
      halfMark <= (rOcc > HALF_P);
    end
  end

  assign rdAddr       = rBin[ADDR_W-1:0];
  assign slipError    = underflowR | ovfAtR[SYNC_STAGES-1];
  assign rdStb.squash = slipError;

endmodule

// File: rtl/elasticDatapath.sv
`timescale 1ns/1ps
module elasticDatapath
  import elasticFifoPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] entry [DEPTH];
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
    end else if (wrStb.store) begin
      entry[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) rdReg <= '0;
    else         rdReg <= entry[rdAddr];
  end

  assign rdData = rdStb.squash ? '0 : rdReg;

endmodule

// File: rtl/elasticTxFifo.sv
`timescale 1ns/1ps
module elasticTxFifo
  import elasticFifoPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  output logic [DATA_W-1:0] rdData,
  output logic              halfMark,
  output logic              slipError
);

  logic              wrRstN, rdRstN;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  wrStrobe_t         wrStb;
  rdStrobe_t         rdStb;

  elasticResetSync #(.STAGES(SYNC_STAGES)) i_wrReset (
    .clk(wrClk), .asyncRstN(rstN), .syncRstN(wrRstN)
  );

  elasticResetSync #(.STAGES(SYNC_STAGES)) i_rdReset (
    .clk(rdClk), .asyncRstN(rstN), .syncRstN(rdRstN)
  );

  elasticCtrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrStb(wrStb), .rdStb(rdStb),
    .halfMark(halfMark), .slipError(slipError)
  );

  elasticDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_data (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrStb(wrStb), .rdStb(rdStb),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/elasticTxFifoChk.sv
`timescale 1ns/1ps
module elasticTxFifoChk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrRstN,
  input logic              rdRstN,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              halfMark,
  input logic              slipError
);

  // one entry written per write cycle, no stall
  p_write_step_r1: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrRstN |=> wrAddr == ADDR_W'($past(wrAddr) + 1'b1));

  // one entry consumed per read cycle, no stall
  p_read_step_r1: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdRstN |=> rdAddr == ADDR_W'($past(rdAddr) + 1'b1));

  // leaving reset with clear status
  p_clear_on_release_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(rdRstN) |-> (!halfMark && !slipError));

  // slip flag holds until reset
  p_sticky_slip_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    slipError |=> slipError);

  // output blanked during a slip
  p_zero_on_slip_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    slipError |-> (rdData == '0));

endmodule

bind elasticTxFifo elasticTxFifoChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrRstN(wrRstN), .rdRstN(rdRstN),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .rdData(rdData),
  .halfMark(halfMark), .slipError(slipError)
);

// File: tb/test_elasticTxFifo.sv
`timescale 1ns/1ps
module test_elasticTxFifo;

  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 4;
  localparam int SYNC_STAGES = 2;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int HALF        = DEPTH / 2;

  logic              wrClk = 1'b0;
  logic              rdClk = 1'b0;
  logic              rstN  = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              halfMark, slipError;

  realtime wrHalf = 5.0, rdHalf = 5.0, rdExtra = 0.0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model[$];
  logic [DATA_W-1:0] expWord = '0;
  logic [DATA_W-1:0] ramp = '0;
  int wCnt = 0, rCnt = 0, rIdx = 0, pattern = 0;
  bit checkData = 1'b0, pending = 1'b0;
  bit seenHalf, seenSlip, slipHadHalf, stickyBroken, zeroBroken;

  elasticTxFifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_elasticTxFifo (
    .wrClk(wrClk), .rstN(rstN), .wrData(wrData), .rdClk(rdClk),
    .rdData(rdData), .halfMark(halfMark), .slipError(slipError)
  );

  initial forever begin
    #(wrHalf) wrClk = ~wrClk;
  end

  initial forever begin
    #(rdHalf) rdClk = ~rdClk;
    if (rdExtra > 0.0) begin
      #(rdExtra);
      rdExtra = 0.0;
    end
  end

  function automatic logic [DATA_W-1:0] nextWord(input int mode, input logic [DATA_W-1:0] prev,
                                                 input logic [DATA_W-1:0] step);
    case (mode)
      1:       return (prev == {DATA_W{1'b1}}) ? '0 : {DATA_W{1'b1}};
      2:       return step;
      default: return DATA_W'($urandom);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive away from the capturing edge
  always @(negedge wrClk) begin
    ramp   <= ramp + 1'b1;
    wrData <= nextWord(pattern, wrData, ramp);
  end

  // model: words enter on active write edges
  always @(posedge wrClk or negedge rstN) begin
    if (!rstN) wCnt = 0;
    else begin
      if (wCnt >= SYNC_STAGES) model.push_back(wrData);
      wCnt++;
    end
  end

  // model: words leave on active read edges
  always @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rCnt    = 0;
      pending = 1'b0;
    end else begin
      if (rCnt >= SYNC_STAGES) begin
        expWord = (model.size() > 0) ? model.pop_front() : '0;
        pending = 1'b1;
      end
      rCnt++;
    end
  end

  always @(negedge rdClk) begin
    if (rstN) begin
      if (pending && checkData) begin
        check(rdData == expWord, (rIdx < HALF) ? "R2" : "R1", "word order",
              32'(rdData), 32'(expWord));
        rIdx++;
      end
      pending = 1'b0;
      if (halfMark) seenHalf = 1'b1;
      if (slipError && !seenSlip) begin
        seenSlip    = 1'b1;
        slipHadHalf = seenHalf;
      end
      if (seenSlip && !slipError) stickyBroken = 1'b1;
      if (slipError && rdData != '0) zeroBroken = 1'b1;
    end
  end

  task automatic applyReset(input realtime wh, input realtime rh, input realtime ex);
    rstN = 1'b0;
    #1;
    check(rdData == '0, "R9", "rdData in reset", 32'(rdData), 0);
    check(!halfMark, "R9", "halfMark in reset", 32'(halfMark), 0);
    check(!slipError, "R9", "slipError in reset", 32'(slipError), 0);
    wrHalf  = wh;
    rdHalf  = rh;
    rdExtra = ex;
    model.delete();
    for (int i = 0; i < HALF; i++) model.push_back('0);
    rIdx = 0;
    seenHalf = 0; seenSlip = 0; slipHadHalf = 0; stickyBroken = 0; zeroBroken = 0;
    repeat (4) @(posedge wrClk);
    #1.37;
    rstN = 1'b1;
  endtask

  task automatic checkCleanStart();
    repeat (2) @(negedge rdClk);
    check(!halfMark && !slipError && rdData == '0, "R9", "status after release",
          {30'd0, halfMark, slipError}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0f1f));

    // matched rates, phase one
    applyReset(5.0, 5.0, 0.0);
    checkCleanStart();
    checkData = 1'b1;
    for (int p = 0; p < 3; p++) begin
      pattern = p;
      repeat (150) @(negedge rdClk);
    end
    checkData = 1'b0;
    check(!seenSlip, "R3", "no slip at matched rate", 32'(seenSlip), 0);
    check(!seenHalf, "R3", "no watermark at matched rate", 32'(seenHalf), 0);

    // matched rates, shifted phase
    applyReset(5.0, 5.0, 2.3);
    pattern = 0;
    checkData = 1'b1;
    repeat (300) @(negedge rdClk);
    checkData = 1'b0;
    check(!seenSlip, "R3", "no slip at shifted phase", 32'(seenSlip), 0);
    check(!seenHalf, "R3", "no watermark at shifted phase", 32'(seenHalf), 0);

    // writes outpace reads: overflow
    applyReset(4.0, 5.0, 0.0);
    for (int i = 0; i < 3000 && !seenSlip; i++) @(negedge rdClk);
    check(seenSlip, "R5", "overflow flagged", 32'(seenSlip), 1);
    check(slipHadHalf, "R4", "watermark before overflow", 32'(slipHadHalf), 1);
    wrHalf = 5.0;
    repeat (200) @(negedge rdClk);
    check(!stickyBroken, "R7", "flag held after rates matched", 32'(stickyBroken), 0);
    check(slipError, "R7", "flag still set", 32'(slipError), 1);
    check(!zeroBroken, "R8", "output zero while flagged", 32'(zeroBroken), 0);
    check(rdData == '0, "R8", "rdData during slip", 32'(rdData), 0);

    // reads outpace writes: underflow
    applyReset(6.0, 5.0, 0.0);
    for (int i = 0; i < 3000 && !seenSlip; i++) @(negedge rdClk);
    check(seenSlip, "R6", "underflow flagged", 32'(seenSlip), 1);
    check(!seenHalf, "R6", "no watermark while draining", 32'(seenHalf), 0);
    repeat (100) @(negedge rdClk);
    check(!stickyBroken, "R7", "underflow flag held", 32'(stickyBroken), 0);
    check(!zeroBroken, "R8", "output zero after underflow", 32'(zeroBroken), 0);

    // reset clears everything and streaming resumes
    applyReset(5.0, 5.0, 0.0);
    checkCleanStart();
    pattern = 2;
    checkData = 1'b1;
    repeat (300) @(negedge rdClk);
    checkData = 1'b0;
    check(!seenSlip, "R9", "clean run after reset", 32'(seenSlip), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule